// File: doc/BRIEF.md
# Processor Bus Adapter with Emulated Parallel Port

This block sits between a stock 8-bit microprocessor and a socket that expects a processor variant with a built-in parallel port. The processor's address, write data and read/write strobe pass through the block to the socket side. Each socket-facing group has an output-enable, so the pad ring can float it whenever another bus master takes the bus, as signalled by the bus-enable input `aec`.

The socket's read/write line is not driven straight from the processor. It comes from a level-sensitive latch that is transparent while the multiplex gate `mux_gate` is high and holds while the gate is low. The latched value reaches the socket only while `aec` is high.

The block also emulates the on-chip port. There is a direction register at address 0x0000 and a data register at address 0x0001. The port has seven pins, bits 0–4, 6 and 7. Bit 5 is absent: it reads as zero and ignores writes. Processor reads of either register are answered internally. Writes to them update the register and are also driven onto the socket bus.

Top module: `cpu_port_adapter`

## Requirements
- R1: While `aec` is 1, `sock_addr_oe` is 1 and `sock_addr_o` equals `cpu_addr`.
- R2: While `aec` is 0, `sock_addr_oe`, `sock_data_oe` and `sock_rw_oe` are all 0, whatever the other inputs are.
- R3: While `mux_gate` is 1, the latched read/write value follows `cpu_rw` (1 = read, 0 = write). `sock_rw_o` carries that value, and `sock_rw_oe` equals `aec`.
- R4: While `mux_gate` is 0, `sock_rw_o` keeps the value it had when the gate fell, even if `cpu_rw` changes. It takes the new `cpu_rw` once the gate rises again.
- R5: After reset, the direction register (0x0000) and the data register (0x0001) both read 0x00, and `port_oe` and `port_o` are 0x00.
- R6: While `aec` is 1 and `cpu_rw` is 0, `sock_data_oe` is 1 and `sock_data_o` equals `cpu_wdata`, including writes to 0x0000 and 0x0001. During any read, `sock_data_oe` is 0.
- R7: A read of 0x0000 or 0x0001 returns the internal register view on `cpu_rdata` and ignores `sock_data_i`. A read of any other address returns `sock_data_i`.
- R8: A write to 0x0000 sets the direction register on the next rising clock edge. `port_oe[i]` equals direction bit i. `port_o[i]` equals data-register bit i.
- R9: A read of 0x0001 returns, for each bit, the data-register bit where the direction bit is 1 and `port_i` where it is 0.
- R10: Bit 5 does not exist. Writes to bit 5 of either register are ignored. `port_oe[5]` and `port_o[5]` stay 0. Bit 5 reads as 0 at both register addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock; registers update on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| aec | input | 1 | Bus enable; 0 floats all socket-facing buses |
| mux_gate | input | 1 | Gate of the read/write latch, transparent when 1 |
| cpu_addr | input | 16 | Address from the processor |
| cpu_rw | input | 1 | Processor read/write, 1 = read |
| cpu_wdata | input | 8 | Write data from the processor |
| cpu_rdata | output | 8 | Read data returned to the processor |
| sock_addr_o | output | 16 | Address toward the socket |
| sock_addr_oe | output | 1 | Enable for `sock_addr_o` |
| sock_data_o | output | 8 | Write data toward the socket |
| sock_data_oe | output | 1 | Enable for `sock_data_o` |
| sock_data_i | input | 8 | Data read from the socket bus |
| sock_rw_o | output | 1 | Latched read/write toward the socket |
| sock_rw_oe | output | 1 | Enable for `sock_rw_o` |
| port_i | input | 8 | Levels sensed on the port pins |
| port_o | output | 8 | Values driven on the port pins |
| port_oe | output | 8 | Per-pin enable for `port_o` |

## Verification
The assertions sample the latch on the clock, so they take for granted that `mux_gate` changes at most once between two rising edges. They also assume it never pulses high and low again inside one period. The register-write checks assume that `cpu_addr`, `cpu_rw` and `cpu_wdata` settle before the rising edge that captures them. The bench drives every input on the falling edge. When it drops the gate, it staggers the gate and the read/write change by a short delay, so that a change on `cpu_rw` while the gate is low always reaches the latch after the gate has closed.

// File: rtl/cpu_port_adapter_pkg.sv
package cpu_port_adapter_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  // Pins that exist on the emulated port; bit 5 is absent.
  localparam logic [DATA_W-1:0] PIN_MASK = 8'hDF;

  function automatic logic addr_match(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] target);
    return a == target;
  endfunction

  // Keep only the bits that exist on the port.
  function automatic logic [DATA_W-1:0] keep_pins(input logic [DATA_W-1:0] v,
                                                  input logic [DATA_W-1:0] mask);
    return v & mask;
  endfunction

  // Read view of the port: outputs show the register, inputs show the pin.
  function automatic logic [DATA_W-1:0] pin_view(input logic [DATA_W-1:0] dir,
                                                 input logic [DATA_W-1:0] dat,
                                                 input logic [DATA_W-1:0] pins,
                                                 input logic [DATA_W-1:0] mask);
    return ((dir & dat) | (~dir & pins)) & mask;
  endfunction

endpackage

// File: rtl/bus_gate.sv
module bus_gate #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          aec,
  input  logic          mux_gate,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rw,
  input  logic [DW-1:0] cpu_wdata,
  output logic [AW-1:0] sock_addr_o,
  output logic          sock_addr_oe,
  output logic [DW-1:0] sock_data_o,
  output logic          sock_data_oe,
  output logic          sock_rw_o,
  output logic          sock_rw_oe,
  output logic          rw_hold
);

  // Transparent while the gate is high, holds while it is low.
  always_latch begin
    if (mux_gate) rw_hold = cpu_rw;
  end

  always_comb begin
    sock_addr_o  = cpu_addr;
    sock_addr_oe = aec;
    sock_data_o  = cpu_wdata;
    sock_data_oe = aec & ~cpu_rw;
    sock_rw_o    = rw_hold;
    sock_rw_oe   = aec;
  end

endmodule

// File: rtl/port_regs.sv
module port_regs
  import cpu_port_adapter_pkg::*;
#(
  parameter int            DW   = 8,
  parameter logic [DW-1:0] MASK = 8'hDF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_dir,
  input  logic          wr_dat,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] dat_q
);

  // Absent pins get no storage; present pins get a resettable flop.
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (MASK[i]) begin : g_real
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dir_q[i] <= 1'b0;
          dat_q[i] <= 1'b0;
        end else begin
          if (wr_dir) dir_q[i] <= wdata[i];
          if (wr_dat) dat_q[i] <= wdata[i];
        end
      end
    end else begin : g_gap
      assign dir_q[i] = 1'b0;
      assign dat_q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/cpu_port_adapter.sv
module cpu_port_adapter
  import cpu_port_adapter_pkg::*;
#(
  parameter int                AW        = ADDR_W,
  parameter int                DW        = DATA_W,
  parameter logic [DW-1:0]     MASK      = PIN_MASK,
  parameter logic [AW-1:0]     DIR_ADDR  = '0,
  parameter logic [AW-1:0]     DAT_ADDR  = AW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          aec,
  input  logic          mux_gate,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rw,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic [AW-1:0] sock_addr_o,
  output logic          sock_addr_oe,
  output logic [DW-1:0] sock_data_o,
  output logic          sock_data_oe,
  input  logic [DW-1:0] sock_data_i,
  output logic          sock_rw_o,
  output logic          sock_rw_oe,
  input  logic [DW-1:0] port_i,
  output logic [DW-1:0] port_o,
  output logic [DW-1:0] port_oe
);

  // Named internal events, also used by the checker.
  logic          hit_dir, hit_dat, reg_hit;
  logic          wr_dir, wr_dat;
  logic          rw_hold;
  logic [DW-1:0] dir_q, dat_q, reg_rdata;

  assign hit_dir = addr_match(cpu_addr, DIR_ADDR);
  assign hit_dat = addr_match(cpu_addr, DAT_ADDR);
  assign reg_hit = hit_dir | hit_dat;
  assign wr_dir  = hit_dir & ~cpu_rw;
  assign wr_dat  = hit_dat & ~cpu_rw;

  bus_gate #(.AW(AW), .DW(DW)) u_gate (
    .aec          (aec),
    .mux_gate     (mux_gate),
    .cpu_addr     (cpu_addr),
    .cpu_rw       (cpu_rw),
    .cpu_wdata    (cpu_wdata),
    .sock_addr_o  (sock_addr_o),
    .sock_addr_oe (sock_addr_oe),
    .sock_data_o  (sock_data_o),
    .sock_data_oe (sock_data_oe),
    .sock_rw_o    (sock_rw_o),
    .sock_rw_oe   (sock_rw_oe),
    .rw_hold      (rw_hold)
  );

  port_regs #(.DW(DW), .MASK(MASK)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_dir (wr_dir),
    .wr_dat (wr_dat),
    .wdata  (cpu_wdata),
    .dir_q  (dir_q),
    .dat_q  (dat_q)
  );

  always_comb begin
    reg_rdata = hit_dir ? keep_pins(dir_q, MASK)
                        : pin_view(dir_q, dat_q, port_i, MASK);
    cpu_rdata = reg_hit ? reg_rdata : sock_data_i;
    port_oe   = keep_pins(dir_q, MASK);
    port_o    = keep_pins(dat_q, MASK);
  end

endmodule

// File: rtl/cpu_port_adapter_chk.sv
module cpu_port_adapter_chk #(
  parameter int            AW   = 16,
  parameter int            DW   = 8,
  parameter logic [DW-1:0] MASK = 8'hDF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          aec,
  input logic          mux_gate,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_rw,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic [AW-1:0] sock_addr_o,
  input logic          sock_addr_oe,
  input logic [DW-1:0] sock_data_o,
  input logic          sock_data_oe,
  input logic          sock_rw_oe,
  input logic          rw_hold,
  input logic          reg_hit,
  input logic          wr_dir,
  input logic          wr_dat,
  input logic [DW-1:0] port_o,
  input logic [DW-1:0] port_oe
);

  AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    aec |-> (sock_addr_oe && sock_addr_o == cpu_addr)); // R1

  AST_FLOAT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !aec |-> (!sock_addr_oe && !sock_data_oe && !sock_rw_oe)); // R2

  AST_RW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    mux_gate |-> (rw_hold == cpu_rw)); // R3

  AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mux_gate && $past(!mux_gate)) |-> $stable(rw_hold)); // R4

  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (aec && !cpu_rw) |-> (sock_data_oe && sock_data_o == cpu_wdata)); // R6

  AST_READ_NODRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rw |-> !sock_data_oe); // R6

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (port_oe == ($past(cpu_wdata) & MASK))); // R8

  AST_DAT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> (port_o == ($past(cpu_wdata) & MASK))); // R8

  AST_GAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_hit && cpu_rw) |-> ((cpu_rdata & ~MASK) == '0)); // R10

  AST_GAP_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (((port_o | port_oe) & ~MASK) == '0)); // R10

endmodule

bind cpu_port_adapter cpu_port_adapter_chk #(.AW(AW), .DW(DW), .MASK(MASK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .aec          (aec),
  .mux_gate     (mux_gate),
  .cpu_addr     (cpu_addr),
  .cpu_rw       (cpu_rw),
  .cpu_wdata    (cpu_wdata),
  .cpu_rdata    (cpu_rdata),
  .sock_addr_o  (sock_addr_o),
  .sock_addr_oe (sock_addr_oe),
  .sock_data_o  (sock_data_o),
  .sock_data_oe (sock_data_oe),
  .sock_rw_oe   (sock_rw_oe),
  .rw_hold      (rw_hold),
  .reg_hit      (reg_hit),
  .wr_dir       (wr_dir),
  .wr_dat       (wr_dat),
  .port_o       (port_o),
  .port_oe      (port_oe)
);

// File: tb/tb_cpu_port_adapter.sv
module tb_cpu_port_adapter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aec = 1'b1;
  logic        mux_gate = 1'b1;
  logic [15:0] cpu_addr = 16'h4000;
  logic        cpu_rw = 1'b1;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic [15:0] sock_addr_o;
  logic        sock_addr_oe;
  logic [7:0]  sock_data_o;
  logic        sock_data_oe;
  logic [7:0]  sock_data_i = 8'h00;
  logic        sock_rw_o;
  logic        sock_rw_oe;
  logic [7:0]  port_i = 8'hFF;
  logic [7:0]  port_o;
  logic [7:0]  port_oe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cpu_port_adapter dut (
    .clk(clk), .rst_n(rst_n), .aec(aec), .mux_gate(mux_gate),
    .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .sock_addr_o(sock_addr_o), .sock_addr_oe(sock_addr_oe),
    .sock_data_o(sock_data_o), .sock_data_oe(sock_data_oe), .sock_data_i(sock_data_i),
    .sock_rw_o(sock_rw_o), .sock_rw_oe(sock_rw_oe), .port_i(port_i),
    .port_o(port_o), .port_oe(port_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Register write: set up on a falling edge, captured on the rising edge.
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rw = 1'b0;
    @(negedge clk);
    cpu_rw = 1'b1; cpu_addr = 16'h4000;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [7:0] sdin);
    @(negedge clk);
    cpu_addr = a; cpu_rw = 1'b1; sock_data_i = sdin;
    #5;
  endtask

  // {aec, rw, addr, wdata, sock_din, exp_addr_oe, exp_data_oe, exp_rdata}
  localparam logic [43:0] VEC [0:6] = '{
    {1'b1, 1'b1, 16'h1234, 8'h00, 8'h5A, 1'b1, 1'b0, 8'h5A},
    {1'b1, 1'b0, 16'h8000, 8'hC3, 8'h00, 1'b1, 1'b1, 8'h00},
    {1'b0, 1'b1, 16'hFFFF, 8'h00, 8'h77, 1'b0, 1'b0, 8'h77},
    {1'b0, 1'b0, 16'h4000, 8'h11, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b1, 1'b1, 16'h0000, 8'h00, 8'hEE, 1'b1, 1'b0, 8'h00},
    {1'b1, 1'b1, 16'h0001, 8'h00, 8'hEE, 1'b1, 1'b0, 8'hDF},
    {1'b1, 1'b1, 16'h0002, 8'h00, 8'h3C, 1'b1, 1'b0, 8'h3C}
  };

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state while reset is held
    check("R5", "port_oe in reset", {8'h0, port_oe}, 16'h0000);
    check("R5", "port_o in reset", {8'h0, port_o}, 16'h0000);
    rst_n = 1'b1;

    // Table: pass-through, floating and read routing (port_i = FF, registers reset)
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      {aec, cpu_rw, cpu_addr, cpu_wdata, sock_data_i} = VEC[k][43:10];
      #5;
      check("R1_R2", "addr_oe", {15'h0, sock_addr_oe}, {15'h0, VEC[k][9]});
      if (aec) check("R1", "addr_o", sock_addr_o, cpu_addr);
      check("R6", "data_oe", {15'h0, sock_data_oe}, {15'h0, VEC[k][8]});
      if (VEC[k][8]) check("R6", "data_o", {8'h0, sock_data_o}, {8'h0, cpu_wdata});
      check("R7_R10", "rdata", {8'h0, cpu_rdata}, {8'h0, VEC[k][7:0]});
      check("R2", "rw_oe", {15'h0, sock_rw_oe}, {15'h0, aec});
    end
    @(negedge clk);
    aec = 1'b1; cpu_rw = 1'b1; cpu_addr = 16'h4000;

    // R6: write to a register address is also driven outward
    @(negedge clk);
    cpu_addr = 16'h0001; cpu_wdata = 8'h3C; cpu_rw = 1'b0;
    #5;
    check("R6", "reg write data_oe", {15'h0, sock_data_oe}, 16'h0001);
    check("R6", "reg write data_o", {8'h0, sock_data_o}, 16'h003C);
    @(negedge clk);
    cpu_rw = 1'b1; cpu_addr = 16'h4000;

    // R8 / R10: direction all ones, bit 5 dropped
    bus_write(16'h0000, 8'hFF);
    #5;
    check("R8", "port_oe after dir write", {8'h0, port_oe}, 16'h00DF);
    bus_write(16'h0001, 8'hA5);
    #5;
    check("R10", "port_o bit5 dropped", {8'h0, port_o}, 16'h0085);
    port_i = 8'h00;
    bus_read(16'h0001, 8'hEE);
    check("R9", "all-output read", {8'h0, cpu_rdata}, 16'h0085);
    check("R6", "no drive on reg read", {15'h0, sock_data_oe}, 16'h0000);

    // R9: mixed direction, pins F0
    bus_write(16'h0000, 8'h0F);
    port_i = 8'hF0;
    bus_read(16'h0001, 8'h00);
    check("R9", "mixed read", {8'h0, cpu_rdata}, 16'h00D5);
    bus_read(16'h0000, 8'hAA);
    check("R7", "dir read", {8'h0, cpu_rdata}, 16'h000F);
    port_i = 8'hFF;
    bus_read(16'h0001, 8'h00);
    check("R10", "bit5 reads 0 with pin high", {11'h0, cpu_rdata[5], 4'h0}, 16'h0000);
    check("R8", "port_oe mixed", {8'h0, port_oe}, 16'h000F);

    // R3 / R4: latch behaviour
    @(negedge clk);
    cpu_addr = 16'h4000; mux_gate = 1'b1; cpu_rw = 1'b1;
    #5;
    check("R3", "rw follows", {15'h0, sock_rw_o}, 16'h0001);
    @(negedge clk);
    mux_gate = 1'b0;
    #2 cpu_rw = 1'b0;
    #3;
    check("R4", "rw held with gate low", {15'h0, sock_rw_o}, 16'h0001);
    @(negedge clk);
    #5;
    check("R4", "rw still held", {15'h0, sock_rw_o}, 16'h0001);
    @(negedge clk);
    mux_gate = 1'b1;
    #5;
    check("R3", "rw updates on gate high", {15'h0, sock_rw_o}, 16'h0000);
    @(negedge clk);
    aec = 1'b0;
    #5;
    check("R2", "rw_oe floats", {15'h0, sock_rw_oe}, 16'h0000);
    check("R2", "data_oe floats on write", {15'h0, sock_data_oe}, 16'h0000);
    @(negedge clk);
    aec = 1'b1; cpu_rw = 1'b1;

    // R5: reset mid-run clears both registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R5", "port_oe after reset", {8'h0, port_oe}, 16'h0000);
    check("R5", "port_o after reset", {8'h0, port_o}, 16'h0000);
    bus_read(16'h0000, 8'h99);
    check("R5", "dir reads 0", {8'h0, cpu_rdata}, 16'h0000);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule